// File: doc/BRIEF.md
# Video-Mode Line and Frame Region Sequencer

This block paces a video-mode display stream in byte-clock cycles. From a set of timing values, it produces the region each cycle belongs to, both along the line and down the frame. It also raises strobes at the start of every line and every frame, and it requests a packet slot for each chunk of an active line and for the null filler that follows each chunk. A low-power-allowed flag tells the lane logic when the link may leave high-speed transmission. Each blanking region has its own enable bit for that flag. Pixel data is not handled here.

A line is counted as sync, then back porch, then active, then front porch. The active stretch is as long as the chunk slots need: one byte cycle per pixel of a chunk, plus the null-packet size. The front porch takes whatever is left of the programmed line time. A frame is counted as sync lines, then back-porch lines, then active lines, then front-porch lines. A region of zero length is skipped. All configuration is captured while the block is idle and again at every frame boundary, so a change made during a frame affects only the frames after it.

Top module: `dsi_vid_timing`

## Requirements
- R1: With `run` high, a line lasts `line_cyc` cycles, where a value of 0 or 1 gives a one-cycle line. Within the line, `h_region` reads 0 (sync) for `hsa_cyc` cycles, then 1 (back porch) for `hbp_cyc` cycles, then 2 (active), then 3 (front porch). Inside one line the region value only ever increases.
- R2: `vblank_cfg` holds the front-porch line count in bits 9:0, the back-porch count in bits 19:10 and the sync count in bits 29:20. `vact_lines` gives the active line count. A frame runs its lines in the order sync (`v_region` 0), back porch (1), active (2), front porch (3). A region with a zero count is skipped. `v_region` changes only on a line start.
- R3: `line_start` is high in the first cycle of every line. `frame_start` is high in the first cycle of every frame, and it coincides with a `line_start`.
- R4: Within an active line, `chunk_req` pulses once per chunk, at the first active cycle and then once every `pkt_size + null_size` cycles. `chunk_num` sets how many chunks a line carries, and a value of 0 means one chunk. `chunk_req` is never high outside active regions of active lines.
- R5: `null_req` pulses `pkt_size` cycles after each `chunk_req`, and the null filler takes up `null_size` cycles of the slot. A `null_size` of 0 produces no null requests and no filler cycles.
- R6: With `mode` 2 or 3 (burst), a line carries one chunk with no null filler, whatever `chunk_num` and `null_size` hold. Mode 0 (sync pulses) and mode 1 (sync events) both follow the chunk settings.
- R7: In a blanking line, `lp_ok` is high outside the horizontal sync region when that line's vertical enable is set. The enable bits are `lp_en[0]` for sync lines, `lp_en[1]` for back-porch lines and `lp_en[2]` for front-porch lines.
- R8: In an active line, `lp_ok` is high only when `lp_en[3]` is set. When it is, the back porch is allowed if `lp_en[4]` is set and the front porch is allowed if `lp_en[5]` is set. `lp_ok` is never high in the sync or active region of an active line.
- R9: Configuration inputs are sampled at frame start. A change made mid-frame leaves the current frame unchanged and applies from the next frame.
- R10: While `run` is low, and after reset, the counters rest at the frame start. `frame_start`, `line_start`, `chunk_req`, `null_req` and `lp_ok` then all stay low.
- R11: If the chunk slots need more cycles than the line leaves, the active region is cut at the line end. The front porch is then empty, and only the requests that fall inside the line are issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Start and keep the sequence running |
| mode | input | 2 | 0 sync pulses, 1 sync events, 2/3 burst |
| hsa_cyc | input | HT_W | Horizontal sync length in byte cycles |
| hbp_cyc | input | HT_W | Horizontal back porch length in byte cycles |
| line_cyc | input | LT_W | Whole line length in byte cycles |
| vblank_cfg | input | 3*VB_W | Vertical sync, back-porch and front-porch line counts |
| vact_lines | input | VA_W | Active line count |
| lp_en | input | 6 | Per-region low-power enables |
| pkt_size | input | PK_W | Pixels (byte cycles) per chunk |
| chunk_num | input | CK_W | Chunks per active line, 0 = one |
| null_size | input | NL_W | Null filler cycles after each chunk |
| h_region | output | 2 | Current horizontal region |
| v_region | output | 2 | Current vertical region |
| lp_ok | output | 1 | Low power allowed this cycle |
| line_start | output | 1 | First cycle of a line |
| frame_start | output | 1 | First cycle of a frame |
| chunk_req | output | 1 | Schedule a video packet chunk |
| null_req | output | 1 | Schedule a null packet |

## Verification
The bench uses the default widths: 16-bit horizontal fields, a 32-bit line time, 10-bit vertical fields and a 10-bit null size. It then programs very short timing values, with lines of 10 to 30 cycles and frames of 3 to 5 lines. As a result, whole frames can be counted cycle by cycle, so every region change, chunk slot and frame wrap can be observed. The short values also make it possible to drive zero-length vertical regions and a chunk train longer than the line, to check burst overrides, and to retime the line in the middle of a frame.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
  localparam int CW = 40;

  typedef enum logic [1:0] {HR_SYNC, HR_BACK, HR_ACT, HR_FRONT} hreg_e;
  typedef enum logic [1:0] {VR_SYNC, VR_BACK, VR_ACT, VR_FRONT} vreg_e;

  // position against three cumulative end points; empty regions fall through
  function automatic logic [1:0] region_of(input logic [CW-1:0] pos,
                                           input logic [CW-1:0] end0,
                                           input logic [CW-1:0] end1,
                                           input logic [CW-1:0] end2);
    if (pos < end0)      return 2'd0;
    else if (pos < end1) return 2'd1;
    else if (pos < end2) return 2'd2;
    else                 return 2'd3;
  endfunction

  function automatic logic is_burst(input logic [1:0] md);
    return md[1];
  endfunction

  // en: [0] vsync [1] vback [2] vfront [3] vactive [4] hback [5] hfront
  function automatic logic lp_gate(input logic [1:0] vr, input logic [1:0] hr,
                                   input logic [5:0] en);
    logic not_sync;
    not_sync = (hr != HR_SYNC);
    case (vr)
      VR_SYNC:  return en[0] & not_sync;
      VR_BACK:  return en[1] & not_sync;
      VR_FRONT: return en[2] & not_sync;
      default:  return en[3] & (((hr == HR_BACK) & en[4]) | ((hr == HR_FRONT) & en[5]));
    endcase
  endfunction
endpackage

// File: rtl/vtg_cfg_hold.sv
module vtg_cfg_hold #(
  parameter int HT_W = 16,
  parameter int LT_W = 32,
  parameter int VB_W = 10,
  parameter int VA_W = 16,
  parameter int PK_W = 16,
  parameter int CK_W = 16,
  parameter int NL_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [1:0]        mode_d,
  input  logic [HT_W-1:0]   hsa_d,
  input  logic [HT_W-1:0]   hbp_d,
  input  logic [LT_W-1:0]   line_d,
  input  logic [3*VB_W-1:0] vblank_d,
  input  logic [VA_W-1:0]   vact_d,
  input  logic [5:0]        lp_d,
  input  logic [PK_W-1:0]   pkt_d,
  input  logic [CK_W-1:0]   chunk_d,
  input  logic [NL_W-1:0]   null_d,
  output logic [1:0]        mode_q,
  output logic [HT_W-1:0]   hsa_q,
  output logic [HT_W-1:0]   hbp_q,
  output logic [LT_W-1:0]   line_q,
  output logic [3*VB_W-1:0] vblank_q,
  output logic [VA_W-1:0]   vact_q,
  output logic [5:0]        lp_q,
  output logic [PK_W-1:0]   pkt_q,
  output logic [CK_W-1:0]   chunk_q,
  output logic [NL_W-1:0]   null_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0; hsa_q <= '0; hbp_q <= '0; line_q <= '0;
      vblank_q <= '0; vact_q <= '0; lp_q <= '0; pkt_q <= '0;
      chunk_q <= '0; null_q <= '0;
    end else if (load) begin
      mode_q <= mode_d; hsa_q <= hsa_d; hbp_q <= hbp_d; line_q <= line_d;
      vblank_q <= vblank_d; vact_q <= vact_d; lp_q <= lp_d; pkt_q <= pkt_d;
      chunk_q <= chunk_d; null_q <= null_d;
    end
  end
endmodule

// File: rtl/vtg_wrap_ctr.sv
module vtg_wrap_ctr #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         step,
  input  logic [W-1:0] limit,
  output logic [W-1:0] cnt,
  output logic         last
);
  assign last = (limit <= W'(1)) || (cnt >= limit - W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (!en)   cnt <= '0;
    else if (step)  cnt <= last ? '0 : cnt + W'(1);
  end
endmodule

// File: rtl/vtg_chunk_slot.sv
module vtg_chunk_slot #(
  parameter int PK_W = 16,
  parameter int NL_W = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_act,
  input  logic            line_end,
  input  logic [PK_W-1:0] pkt,
  input  logic [NL_W-1:0] nul,
  output logic            slot_first,
  output logic            slot_null
);
  localparam int SW = PK_W + 1;
  logic [SW-1:0] slot, slot_len;

  assign slot_len = SW'(pkt) + SW'(nul);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot <= '0;
    else if (!in_act || line_end || (slot + SW'(1)) >= slot_len) slot <= '0;
    else slot <= slot + SW'(1);
  end

  assign slot_first = in_act && (slot == '0);
  assign slot_null  = in_act && (nul != '0) && (slot == SW'(pkt));
endmodule

// File: rtl/dsi_vid_timing.sv
module dsi_vid_timing
  import vtg_pkg::*;
#(
  parameter int HT_W = 16,
  parameter int LT_W = 32,
  parameter int VB_W = 10,
  parameter int VA_W = 16,
  parameter int PK_W = 16,
  parameter int CK_W = 16,
  parameter int NL_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [1:0]        mode,
  input  logic [HT_W-1:0]   hsa_cyc,
  input  logic [HT_W-1:0]   hbp_cyc,
  input  logic [LT_W-1:0]   line_cyc,
  input  logic [3*VB_W-1:0] vblank_cfg,
  input  logic [VA_W-1:0]   vact_lines,
  input  logic [5:0]        lp_en,
  input  logic [PK_W-1:0]   pkt_size,
  input  logic [CK_W-1:0]   chunk_num,
  input  logic [NL_W-1:0]   null_size,
  output logic [1:0]        h_region,
  output logic [1:0]        v_region,
  output logic              lp_ok,
  output logic              line_start,
  output logic              frame_start,
  output logic              chunk_req,
  output logic              null_req
);
  localparam int FW = ((VA_W > VB_W) ? VA_W : VB_W) + 2;

  logic              running;
  logic              cfg_load;
  logic [1:0]        mode_q;
  logic [HT_W-1:0]   hsa_q, hbp_q;
  logic [LT_W-1:0]   line_q;
  logic [3*VB_W-1:0] vblank_q;
  logic [VA_W-1:0]   vact_q;
  logic [5:0]        lp_q;
  logic [PK_W-1:0]   pkt_q;
  logic [CK_W-1:0]   chunk_q;
  logic [NL_W-1:0]   null_q;

  // named internal events
  logic [LT_W-1:0] hcnt;
  logic [FW-1:0]   vidx, frame_lines;
  logic            h_last, v_last, frame_wrap;
  logic [CK_W-1:0] eff_chunks;
  logic [NL_W-1:0] eff_null;
  logic [CW-1:0]   sync_end, back_end, act_end, act_len;
  logic [VB_W-1:0] vsa_n, vbp_n, vfp_n;
  logic            slot_first, slot_null;
  logic            in_act, v_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) running <= 1'b0;
    else        running <= run;
  end

  assign frame_wrap = running && h_last && v_last;
  assign cfg_load   = !running || frame_wrap;

  vtg_cfg_hold #(.HT_W(HT_W), .LT_W(LT_W), .VB_W(VB_W), .VA_W(VA_W),
                 .PK_W(PK_W), .CK_W(CK_W), .NL_W(NL_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .load(cfg_load),
    .mode_d(mode), .hsa_d(hsa_cyc), .hbp_d(hbp_cyc), .line_d(line_cyc),
    .vblank_d(vblank_cfg), .vact_d(vact_lines), .lp_d(lp_en), .pkt_d(pkt_size),
    .chunk_d(chunk_num), .null_d(null_size),
    .mode_q(mode_q), .hsa_q(hsa_q), .hbp_q(hbp_q), .line_q(line_q),
    .vblank_q(vblank_q), .vact_q(vact_q), .lp_q(lp_q), .pkt_q(pkt_q),
    .chunk_q(chunk_q), .null_q(null_q)
  );

  assign vfp_n = vblank_q[VB_W-1:0];
  assign vbp_n = vblank_q[2*VB_W-1:VB_W];
  assign vsa_n = vblank_q[3*VB_W-1:2*VB_W];
  assign frame_lines = FW'(vsa_n) + FW'(vbp_n) + FW'(vact_q) + FW'(vfp_n);

  assign eff_chunks = (is_burst(mode_q) || chunk_q == '0) ? CK_W'(1) : chunk_q;
  assign eff_null   = is_burst(mode_q) ? '0 : null_q;
  assign act_len    = CW'(eff_chunks) * (CW'(pkt_q) + CW'(eff_null));
  assign sync_end   = CW'(hsa_q);
  assign back_end   = sync_end + CW'(hbp_q);
  assign act_end    = back_end + act_len;

  vtg_wrap_ctr #(.W(LT_W)) u_hctr (
    .clk(clk), .rst_n(rst_n), .en(running), .step(1'b1),
    .limit(line_q), .cnt(hcnt), .last(h_last)
  );

  vtg_wrap_ctr #(.W(FW)) u_vctr (
    .clk(clk), .rst_n(rst_n), .en(running), .step(h_last),
    .limit(frame_lines), .cnt(vidx), .last(v_last)
  );

  assign h_region = region_of(CW'(hcnt), sync_end, back_end, act_end);
  assign v_region = region_of(CW'(vidx), CW'(vsa_n), CW'(vsa_n) + CW'(vbp_n),
                              CW'(vsa_n) + CW'(vbp_n) + CW'(vact_q));
  assign in_act = (h_region == HR_ACT);
  assign v_act  = (v_region == VR_ACT);

  vtg_chunk_slot #(.PK_W(PK_W), .NL_W(NL_W)) u_slot (
    .clk(clk), .rst_n(rst_n), .in_act(in_act), .line_end(h_last),
    .pkt(pkt_q), .nul(eff_null), .slot_first(slot_first), .slot_null(slot_null)
  );

  assign line_start  = running && (hcnt == '0);
  assign frame_start = line_start && (vidx == '0);
  assign chunk_req   = running && v_act && slot_first;
  assign null_req    = running && v_act && slot_null;
  assign lp_ok       = running && lp_gate(v_region, h_region, lp_q);
endmodule

// File: rtl/dsi_vid_timing_chk.sv
module dsi_vid_timing_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       running,
  input logic [1:0] h_region,
  input logic [1:0] v_region,
  input logic       lp_ok,
  input logic       line_start,
  input logic       frame_start,
  input logic       chunk_req,
  input logic       null_req
);
  logic seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;
  end

  assert_h_order_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && running && $past(running) && !line_start && h_region != $past(h_region))
      |-> (h_region == 2'($past(h_region) + 2'd1)));

  assert_v_change_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && running && $past(running) && v_region != $past(v_region)) |-> line_start);

  assert_chunk_place_R4: assert property (@(posedge clk) disable iff (!rst_n)
    chunk_req |-> (h_region == 2'd2 && v_region == 2'd2));

  assert_lp_active_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_ok && v_region == 2'd2) |-> (h_region == 2'd1 || h_region == 2'd3));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (!frame_start && !line_start && !lp_ok && !chunk_req && !null_req));
endmodule

bind dsi_vid_timing dsi_vid_timing_chk u_chk (
  .clk(clk), .rst_n(rst_n), .running(running), .h_region(h_region),
  .v_region(v_region), .lp_ok(lp_ok), .line_start(line_start),
  .frame_start(frame_start), .chunk_req(chunk_req), .null_req(null_req)
);

// File: tb/dsi_vid_timing_tb.sv
module dsi_vid_timing_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic [1:0]  mode = '0;
  logic [15:0] hsa_cyc = '0, hbp_cyc = '0;
  logic [31:0] line_cyc = '0;
  logic [29:0] vblank_cfg = '0;
  logic [15:0] vact_lines = '0;
  logic [5:0]  lp_en = '0;
  logic [15:0] pkt_size = '0, chunk_num = '0;
  logic [9:0]  null_size = '0;
  logic [1:0]  h_region, v_region;
  logic        lp_ok, line_start, frame_start, chunk_req, null_req;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  dsi_vid_timing u_dut (
    .clk(clk), .rst_n(rst_n), .run(run), .mode(mode), .hsa_cyc(hsa_cyc),
    .hbp_cyc(hbp_cyc), .line_cyc(line_cyc), .vblank_cfg(vblank_cfg),
    .vact_lines(vact_lines), .lp_en(lp_en), .pkt_size(pkt_size),
    .chunk_num(chunk_num), .null_size(null_size), .h_region(h_region),
    .v_region(v_region), .lp_ok(lp_ok), .line_start(line_start),
    .frame_start(frame_start), .chunk_req(chunk_req), .null_req(null_req)
  );

  // stimulus and expected per-frame totals
  localparam int NV = 5;
  localparam int T_HSA [NV] = '{2, 2, 2, 2, 2};
  localparam int T_HBP [NV] = '{3, 3, 3, 3, 3};
  localparam int T_LINE[NV] = '{20, 20, 20, 10, 20};
  localparam int T_VSA [NV] = '{1, 1, 1, 1, 0};
  localparam int T_VBP [NV] = '{1, 1, 1, 1, 0};
  localparam int T_VACT[NV] = '{2, 2, 2, 2, 1};
  localparam int T_VFP [NV] = '{1, 1, 1, 1, 2};
  localparam int T_PKT [NV] = '{4, 4, 6, 4, 4};
  localparam int T_CHK [NV] = '{2, 2, 0, 3, 2};
  localparam int T_NUL [NV] = '{2, 2, 0, 1, 2};
  localparam int T_MODE[NV] = '{0, 2, 0, 1, 0};
  localparam int T_LP  [NV] = '{63, 63, 5, 63, 52};
  localparam int E_CYC [NV] = '{100, 100, 100, 50, 60};
  localparam int E_LINE[NV] = '{5, 5, 5, 5, 3};
  localparam int E_CHK [NV] = '{4, 2, 2, 2, 2};
  localparam int E_NUL [NV] = '{4, 0, 0, 2, 2};
  localparam int E_LPC [NV] = '{66, 82, 36, 30, 36};
  localparam int E_VR0 [NV] = '{0, 0, 0, 0, 2};

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic load_vec(input int i);
    hsa_cyc = 16'(T_HSA[i]); hbp_cyc = 16'(T_HBP[i]); line_cyc = 32'(T_LINE[i]);
    vblank_cfg = {10'(T_VSA[i]), 10'(T_VBP[i]), 10'(T_VFP[i])};
    vact_lines = 16'(T_VACT[i]); pkt_size = 16'(T_PKT[i]);
    chunk_num = 16'(T_CHK[i]); null_size = 10'(T_NUL[i]);
    mode = 2'(T_MODE[i]); lp_en = 6'(T_LP[i]);
  endtask

  task automatic wait_fs(output bit ok);
    ok = 1'b0;
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      if (frame_start) begin ok = 1'b1; break; end
    end
  endtask

  // counts one frame from a negedge where frame_start is high
  task automatic measure(input int chg_at, input int chg_line,
                         output int cyc, output int ch, output int nu,
                         output int lp, output int ls);
    cyc = 0; ch = 0; nu = 0; lp = 0; ls = 0;
    forever begin
      ch += int'(chunk_req); nu += int'(null_req);
      lp += int'(lp_ok); ls += int'(line_start);
      cyc++;
      if (cyc == chg_at) line_cyc = 32'(chg_line);
      @(negedge clk);
      if (frame_start || cyc > 5000) break;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int cyc, ch, nu, lp, ls;
    bit ok;
    // reset and idle, R10
    repeat (3) @(negedge clk);
    check("R10 reset frame_start", int'(frame_start), 0);
    check("R10 reset lp_ok", int'(lp_ok), 0);
    rst_n = 1'b1;
    load_vec(0);
    repeat (4) @(negedge clk);
    check("R10 idle strobes", int'(frame_start | line_start | chunk_req | null_req), 0);
    check("R10 idle lp_ok", int'(lp_ok), 0);

    for (int i = 0; i < NV; i++) begin
      run = 1'b0;
      load_vec(i);
      repeat (3) @(negedge clk);
      run = 1'b1;
      wait_fs(ok);
      check("R3 frame_start seen", int'(ok), 1);
      check("R3 frame_start with line_start", int'(line_start), 1);
      check("R2 first v_region", int'(v_region), E_VR0[i]);
      check("R1 first h_region", int'(h_region), 0);
      measure(0, 0, cyc, ch, nu, lp, ls);
      check("R1 R11 frame cycles", cyc, E_CYC[i]);
      check("R2 R3 lines per frame", ls, E_LINE[i]);
      check("R4 R6 R11 chunk count", ch, E_CHK[i]);
      check("R5 R6 R11 null count", nu, E_NUL[i]);
      check("R7 R8 lp_ok cycles", lp, E_LPC[i]);
    end

    // mid-frame change applies only from next frame, R9
    run = 1'b0;
    load_vec(0);
    repeat (3) @(negedge clk);
    run = 1'b1;
    wait_fs(ok);
    measure(10, 30, cyc, ch, nu, lp, ls);
    check("R9 current frame unchanged", cyc, 100);
    measure(0, 0, cyc, ch, nu, lp, ls);
    check("R9 next frame retimed", cyc, 150);

    // stopping returns to idle, R10
    run = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 stopped strobes", int'(frame_start | line_start | chunk_req | lp_ok), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule